// File: doc/BRIEF.md
# Processor Sleep Mode Controller

This block decides when a small processor core stops running and which clocks and power domains go down with it. Instruction decode sends it one-cycle request pulses for three kinds of entry: an unconditional wait-for-interrupt, a conditional wait-for-event, and a return from an exception to thread mode, which only counts when the sleep-on-exit control bit is set. A deep-sleep select bit, set by software before entry, chooses between a light sleep that gates only the processor clock and a deep sleep that also drops the system clock, the PLL power and the memory power.

A one-bit event latch remembers any external event seen while the core runs, so that a later wait-for-event uses up the event and keeps running. The core wakes on a pending prioritised interrupt, on an external event if wait-for-event alone caused the entry, or, in deep sleep only, on a request from a separate wake-up controller. Leaving deep sleep restores the enables in a fixed order with parameterised settle times. The outputs are plain enable levels for gating cells and power switches elsewhere.

Top module: `slp_power_ctrl`

## Requirements
- R1: After reset all four enables are 1, core_stall is 0 and the event latch is clear.
- R2: A req_wfi pulse while running enters sleep in the next cycle without condition; if several requests coincide, the event wake source is armed only when req_wfe alone caused the entry.
- R3: A req_wfe pulse while running enters sleep when the event latch is clear and ext_event is low in that cycle; otherwise the core keeps running and the latch is cleared.
- R4: An ext_event pulse while running, without req_wfe in the same cycle, sets the event latch.
- R5: A req_exc_ret pulse enters sleep only when sleep_on_exit is 1; with sleep_on_exit at 0 it has no effect.
- R6: deep_sel sampled with the entry request picks the mode: 0 clears only cpu_clk_en; 1 clears cpu_clk_en, sys_clk_en, pll_pwr_en and mem_pwr_en. core_stall is 1 in every non-running state.
- R7: In light sleep, irq_pending returns all enables to 1 and core_stall to 0 in the next cycle; ext_event wakes only after an entry by req_wfe alone.
- R8: After an entry by req_wfe alone, either irq_pending or ext_event wakes the core.
- R9: wake_ctl_req wakes the core from deep sleep and has no effect in light sleep.
- R10: On leaving deep sleep, mem_pwr_en and pll_pwr_en rise first and stay alone for PWR_WAIT cycles, then sys_clk_en rises for SYS_WAIT cycles, then cpu_clk_en rises and core_stall falls.
- R11: Entry requests that arrive while asleep or during the deep-sleep restore sequence are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| req_wfi | input | 1 | Wait-for-interrupt request pulse |
| req_wfe | input | 1 | Wait-for-event request pulse |
| req_exc_ret | input | 1 | Exception return to thread mode pulse |
| sleep_on_exit | input | 1 | Sleep on exception return enable |
| deep_sel | input | 1 | 1 selects deep sleep at entry |
| irq_pending | input | 1 | Pending prioritised interrupt |
| ext_event | input | 1 | External event input |
| wake_ctl_req | input | 1 | Wake-up controller request |
| cpu_clk_en | output | 1 | Processor clock enable |
| sys_clk_en | output | 1 | System clock enable |
| pll_pwr_en | output | 1 | PLL power enable |
| mem_pwr_en | output | 1 | Memory power enable |
| core_stall | output | 1 | Core held, not executing |

## Verification
Directed sequences walk each entry kind into each sleep depth and then try every wake source against it, which separates the wait-for-event wake set from the interrupt-only set and the deep-only wake-up controller path. Event pulses before, with and after a wait-for-event show whether the latch is consumed or bypassed. A long seeded random run mixes coincident requests, mode changes and wake sources against a cycle model of the requirements, which exposes ordering or settle-count errors in the deep-sleep restore sequence.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_LITE  = 3'd1,
        ST_DEEP  = 3'd2,
        ST_PWRUP = 3'd3,
        ST_CLKUP = 3'd4
    } slp_state_e;

    typedef enum logic [1:0] {
        TRIG_NONE = 2'd0,
        TRIG_WFI  = 2'd1,
        TRIG_EXIT = 2'd2,
        TRIG_WFE  = 2'd3
    } slp_trig_e;

    typedef struct packed {
        logic mem;
        logic pll;
        logic sys;
        logic cpu;
        logic stall;
    } slp_en_t;

    function automatic slp_en_t en_for_state(slp_state_e s);
        slp_en_t e;
        e = '{mem: 1'b1, pll: 1'b1, sys: 1'b1, cpu: 1'b1, stall: 1'b0};
        case (s)
            ST_RUN:   e = '{mem: 1'b1, pll: 1'b1, sys: 1'b1, cpu: 1'b1, stall: 1'b0};
            ST_LITE:  e = '{mem: 1'b1, pll: 1'b1, sys: 1'b1, cpu: 1'b0, stall: 1'b1};
            ST_DEEP:  e = '{mem: 1'b0, pll: 1'b0, sys: 1'b0, cpu: 1'b0, stall: 1'b1};
            ST_PWRUP: e = '{mem: 1'b1, pll: 1'b1, sys: 1'b0, cpu: 1'b0, stall: 1'b1};
            ST_CLKUP: e = '{mem: 1'b1, pll: 1'b1, sys: 1'b1, cpu: 1'b0, stall: 1'b1};
            default:  e = '{mem: 1'b1, pll: 1'b1, sys: 1'b1, cpu: 1'b1, stall: 1'b0};
        endcase
        return e;
    endfunction

    function automatic int max_int(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/slp_event_latch.sv
module slp_event_latch (
    input  logic clk,
    input  logic rst,
    input  logic running,
    input  logic ext_event,
    input  logic wfe_req,
    output logic evt_seen
);
    logic evt_q;

    assign evt_seen = evt_q | ext_event;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= 1'b0;
        end else if (running) begin
            evt_q <= wfe_req ? 1'b0 : evt_seen;
        end
    end

    assert_evt_capture_R4: assert property (@(posedge clk) disable iff (rst)
        (running && ext_event && !wfe_req) |=> evt_q);

    assert_evt_consume_R3: assert property (@(posedge clk) disable iff (rst)
        (running && wfe_req) |=> !evt_q);

endmodule

// File: rtl/slp_entry_dec.sv
module slp_entry_dec
    import slp_pkg::*;
(
    input  logic      running,
    input  logic      req_wfi,
    input  logic      req_wfe,
    input  logic      req_exc_ret,
    input  logic      sleep_on_exit,
    input  logic      evt_seen,
    output logic      go_sleep,
    output slp_trig_e trig
);
    logic exit_hit;
    logic wfe_hit;

    always_comb begin
        exit_hit = running && req_exc_ret && sleep_on_exit;
        wfe_hit  = running && req_wfe && !evt_seen;
        trig     = TRIG_NONE;
        if (running && req_wfi) begin
            trig = TRIG_WFI;
        end else if (exit_hit) begin
            trig = TRIG_EXIT;
        end else if (wfe_hit) begin
            trig = TRIG_WFE;
        end
        go_sleep = (trig != TRIG_NONE);
    end

endmodule

// File: rtl/slp_restore_timer.sv
module slp_restore_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    assign done = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (!done) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_timer_step_R10: assert property (@(posedge clk) disable iff (rst)
        (!load && !done) |=> (cnt_q == $past(cnt_q) - 1'b1));

    assert_timer_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!load && done) |=> done);

endmodule

// File: rtl/slp_power_ctrl.sv
module slp_power_ctrl
    import slp_pkg::*;
#(
    parameter int PWR_WAIT = 4,
    parameter int SYS_WAIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic req_wfi,
    input  logic req_wfe,
    input  logic req_exc_ret,
    input  logic sleep_on_exit,
    input  logic deep_sel,
    input  logic irq_pending,
    input  logic ext_event,
    input  logic wake_ctl_req,
    output logic cpu_clk_en,
    output logic sys_clk_en,
    output logic pll_pwr_en,
    output logic mem_pwr_en,
    output logic core_stall
);
    localparam int            MAX_WAIT = max_int(PWR_WAIT, SYS_WAIT);
    localparam int            CW       = $clog2(MAX_WAIT + 1);
    localparam logic [CW-1:0] PWR_LD   = CW'(PWR_WAIT - 1);
    localparam logic [CW-1:0] SYS_LD   = CW'(SYS_WAIT - 1);

    slp_state_e    state_q, state_n;
    logic          wfe_mode_q, wfe_mode_n;
    logic          running;
    logic          evt_seen;
    logic          go_sleep;
    slp_trig_e     trig;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;
    logic          wake_common;
    slp_en_t       en;

    assign running = (state_q == ST_RUN);

    slp_event_latch u_evt (
        .clk       (clk),
        .rst       (rst),
        .running   (running),
        .ext_event (ext_event),
        .wfe_req   (req_wfe),
        .evt_seen  (evt_seen)
    );

    slp_entry_dec u_entry (
        .running       (running),
        .req_wfi       (req_wfi),
        .req_wfe       (req_wfe),
        .req_exc_ret   (req_exc_ret),
        .sleep_on_exit (sleep_on_exit),
        .evt_seen      (evt_seen),
        .go_sleep      (go_sleep),
        .trig          (trig)
    );

    slp_restore_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    assign wake_common = irq_pending || (wfe_mode_q && ext_event);

    always_comb begin
        state_n    = state_q;
        wfe_mode_n = wfe_mode_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        case (state_q)
            ST_RUN: begin
                if (go_sleep) begin
                    state_n    = deep_sel ? ST_DEEP : ST_LITE;
                    wfe_mode_n = (trig == TRIG_WFE);
                end
            end
            ST_LITE: begin
                if (wake_common) begin
                    state_n = ST_RUN;
                end
            end
            ST_DEEP: begin
                if (wake_common || wake_ctl_req) begin
                    state_n  = ST_PWRUP;
                    tmr_load = 1'b1;
                    tmr_val  = PWR_LD;
                end
            end
            ST_PWRUP: begin
                if (tmr_done) begin
                    state_n  = ST_CLKUP;
                    tmr_load = 1'b1;
                    tmr_val  = SYS_LD;
                end
            end
            ST_CLKUP: begin
                if (tmr_done) begin
                    state_n = ST_RUN;
                end
            end
            default: state_n = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_RUN;
            wfe_mode_q <= 1'b0;
        end else begin
            state_q    <= state_n;
            wfe_mode_q <= wfe_mode_n;
        end
    end

    assign en         = en_for_state(state_q);
    assign cpu_clk_en = en.cpu;
    assign sys_clk_en = en.sys;
    assign pll_pwr_en = en.pll;
    assign mem_pwr_en = en.mem;
    assign core_stall = en.stall;

    assert_wfi_sleeps_R2: assert property (@(posedge clk) disable iff (rst)
        (running && req_wfi) |=> (core_stall && !cpu_clk_en));

    assert_exit_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (running && req_exc_ret && !sleep_on_exit && !req_wfi && !req_wfe) |=> !core_stall);

    assert_lite_irq_wake_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LITE && irq_pending) |=> !core_stall);

    assert_wkc_lite_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LITE && wake_ctl_req && !irq_pending && !ext_event) |=> core_stall);

    assert_cpu_last_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk_en) |-> (sys_clk_en && pll_pwr_en && mem_pwr_en));

    assert_sys_after_pwr_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_clk_en) |-> (pll_pwr_en && mem_pwr_en && $past(mem_pwr_en)));

    assert_asleep_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PWRUP && !tmr_done) |=> $stable(core_stall));

endmodule

// File: tb/slp_power_ctrl_bench.sv
module slp_power_ctrl_bench;
    localparam int PWR_WAIT = 4;
    localparam int SYS_WAIT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_wfi = 0, req_wfe = 0, req_exc_ret = 0, sleep_on_exit = 0;
    logic deep_sel = 0, irq_pending = 0, ext_event = 0, wake_ctl_req = 0;
    logic cpu_clk_en, sys_clk_en, pll_pwr_en, mem_pwr_en, core_stall;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    string cur_tag = "R1";
    bit use_state_tag = 0;

    int m_st = 0;
    bit m_latch = 0;
    bit m_wfe = 0;
    int m_cnt = 0;

    always #5 clk = ~clk;

    slp_power_ctrl #(.PWR_WAIT(PWR_WAIT), .SYS_WAIT(SYS_WAIT)) u_slp_power_ctrl (
        .clk(clk), .rst(rst), .req_wfi(req_wfi), .req_wfe(req_wfe),
        .req_exc_ret(req_exc_ret), .sleep_on_exit(sleep_on_exit),
        .deep_sel(deep_sel), .irq_pending(irq_pending), .ext_event(ext_event),
        .wake_ctl_req(wake_ctl_req), .cpu_clk_en(cpu_clk_en),
        .sys_clk_en(sys_clk_en), .pll_pwr_en(pll_pwr_en),
        .mem_pwr_en(mem_pwr_en), .core_stall(core_stall)
    );

    // Reference model written from the requirements.
    always @(posedge clk) begin
        bit evs;
        bit exit_ok;
        if (rst) begin
            m_st = 0; m_latch = 0; m_wfe = 0; m_cnt = 0;
        end else begin
            case (m_st)
                0: begin
                    evs = m_latch | ext_event;
                    exit_ok = req_exc_ret & sleep_on_exit;
                    m_latch = req_wfe ? 1'b0 : evs;
                    if (req_wfi || exit_ok || (req_wfe && !evs)) begin
                        m_wfe = !req_wfi && !exit_ok;
                        m_st = deep_sel ? 2 : 1;
                    end
                end
                1: if (irq_pending || (m_wfe && ext_event)) m_st = 0;
                2: if (irq_pending || (m_wfe && ext_event) || wake_ctl_req) begin
                    m_st = 3; m_cnt = PWR_WAIT;
                end
                3: begin
                    m_cnt--;
                    if (m_cnt == 0) begin m_st = 4; m_cnt = SYS_WAIT; end
                end
                default: begin
                    m_cnt--;
                    if (m_cnt == 0) m_st = 0;
                end
            endcase
        end
    end

    // {mem, pll, sys, cpu, stall}
    function automatic logic [4:0] exp_out(int st);
        case (st)
            0: return 5'b11110;
            1: return 5'b11101;
            2: return 5'b00001;
            3: return 5'b11001;
            default: return 5'b11101;
        endcase
    endfunction

    function automatic string tag_for(int st);
        case (st)
            0: return "R2";
            1: return "R7";
            2: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic compare();
        logic [4:0] act;
        logic [4:0] exp;
        string t;
        act = {mem_pwr_en, pll_pwr_en, sys_clk_en, cpu_clk_en, core_stall};
        exp = exp_out(m_st);
        t = use_state_tag ? tag_for(m_st) : cur_tag;
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %b expected %b", t, cyc, act, exp);
        end
    endtask

    // One clock: edge, then check away from it at the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic clear_reqs();
        req_wfi = 0; req_wfe = 0; req_exc_ret = 0;
        irq_pending = 0; ext_event = 0; wake_ctl_req = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
            report();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        cur_tag = "R1";
        tick();

        // R3: WFE with clear latch sleeps (also shows latch clear after reset, R1)
        cur_tag = "R3";
        req_wfe = 1; tick(); clear_reqs(); tick();
        // R8: ext_event wakes WFE sleep
        cur_tag = "R8";
        ext_event = 1; tick(); clear_reqs(); tick();

        // R4: event while running sets latch; WFE then keeps running (R3)
        cur_tag = "R4";
        ext_event = 1; tick(); clear_reqs(); tick();
        cur_tag = "R3";
        req_wfe = 1; tick(); clear_reqs(); tick();
        req_wfe = 1; tick(); clear_reqs(); tick();
        // R3: event in same cycle as WFE bypasses sleep
        cur_tag = "R8";
        irq_pending = 1; tick(); clear_reqs(); tick();
        cur_tag = "R3";
        req_wfe = 1; ext_event = 1; tick(); clear_reqs(); tick();

        // R2 + R6 light: WFI sleeps, only cpu clock off
        cur_tag = "R2";
        deep_sel = 0;
        req_wfi = 1; tick(); clear_reqs(); tick();
        // R7: ext_event does not wake a WFI sleep
        cur_tag = "R7";
        ext_event = 1; tick(); clear_reqs(); tick();
        // R9: wake controller ignored in light sleep
        cur_tag = "R9";
        wake_ctl_req = 1; tick(); clear_reqs(); tick();
        // R11: new requests while asleep ignored
        cur_tag = "R11";
        req_wfe = 1; req_wfi = 1; req_exc_ret = 1; tick(); clear_reqs(); tick();
        cur_tag = "R7";
        irq_pending = 1; tick(); clear_reqs(); tick();

        // R5: exception return without sleep_on_exit ignored, with it sleeps
        cur_tag = "R5";
        sleep_on_exit = 0;
        req_exc_ret = 1; tick(); clear_reqs(); tick();
        sleep_on_exit = 1;
        req_exc_ret = 1; tick(); clear_reqs(); tick();
        irq_pending = 1; tick(); clear_reqs(); tick();
        sleep_on_exit = 0;

        // R2: WFI and WFE together arm no event wake
        cur_tag = "R2";
        req_wfi = 1; req_wfe = 1; tick(); clear_reqs();
        ext_event = 1; tick(); clear_reqs(); tick();
        irq_pending = 1; tick(); clear_reqs(); tick();

        // R6 deep: all off; R9 wake controller wakes; R10 restore order
        cur_tag = "R6";
        deep_sel = 1;
        req_wfi = 1; tick(); clear_reqs(); tick(); tick();
        cur_tag = "R9";
        wake_ctl_req = 1; tick(); clear_reqs();
        cur_tag = "R10";
        for (int i = 0; i < PWR_WAIT - 1; i++) begin
            if (i == 1) begin
                cur_tag = "R11";
                req_wfi = 1; tick(); clear_reqs();
                cur_tag = "R10";
            end else begin
                tick();
            end
        end
        for (int i = 0; i < SYS_WAIT + 2; i++) tick();

        // R8: WFE into deep sleep wakes on ext_event through the sequence
        cur_tag = "R8";
        req_wfe = 1; tick(); clear_reqs(); tick();
        ext_event = 1; tick(); clear_reqs();
        for (int i = 0; i < PWR_WAIT + SYS_WAIT + 2; i++) tick();
        deep_sel = 0;

        // Seeded random mix, tags follow the model state
        use_state_tag = 1;
        for (int n = 0; n < 4000; n++) begin
            req_wfi      = ($urandom % 25) == 0;
            req_wfe      = ($urandom % 20) == 0;
            req_exc_ret  = ($urandom % 20) == 0;
            irq_pending  = ($urandom % 12) == 0;
            ext_event    = ($urandom % 10) == 0;
            wake_ctl_req = ($urandom % 15) == 0;
            if (($urandom % 30) == 0) deep_sel = ~deep_sel;
            if (($urandom % 40) == 0) sleep_on_exit = ~sleep_on_exit;
            tick();
        end
        clear_reqs();
        tick();
        report();
    end

endmodule